// File: doc/BRIEF.md
# Prefix-Tree Unsigned Magnitude Comparator

This block is a purely combinational comparator for two unsigned operands of a parameterised width. It raises exactly one of three flags: the first operand is larger, the first operand is smaller, or the two are equal. There is no clock and no state. The flags settle one combinational path after the operands change.

Internally the block does not use a subtractor or a bit-serial cascade. Every bit pair is tested for a difference. Groups of four bits each report whether they contain a difference. A suffix AND over those group reports, together with at most three in-group neighbours, enables exactly one bit position: the most significant one that differs. That bit alone steers its operand bits onto a pair of one-hot direction buses. Every other bit drives zero. A NOR-then-NAND reduction of each bus gives the greater and smaller flags, and equality is the absence of both. Every AND in the enable tier has five inputs or fewer at any width.

Top module: `pfx_mag_cmp`

## Requirements
- R1: `a_gt_b` is 1 exactly when `op_a` is greater than `op_b`, with both read as unsigned integers.
- R2: `a_lt_b` is 1 exactly when `op_a` is less than `op_b`, with both read as unsigned integers.
- R3: `a_eq_b` is 1 exactly when the operands are identical. Exactly one of the three flags is 1 for every input pair.
- R4: Only the most significant differing bit decides the result. Lower bits that differ in the opposite direction have no effect (for 8 bits, `op_a`=0x80 against `op_b`=0x7F gives `a_gt_b`).
- R5: Operands that differ only in bit 0 are reported as unequal, with the direction set by bit 0.
- R6: Operands that differ in bit N-1 are ordered by that bit alone, whatever the lower bits hold.
- R7: Width parameter `N` must be a positive multiple of 4 (elaboration fails otherwise). R1 to R6 hold unchanged at N=8 and at N=32.
- R8: At most one bit position drives a nonzero pair onto the direction buses, and no position drives both buses at once. As a result, `a_gt_b` and `a_lt_b` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First unsigned operand |
| op_b | input | N | Second unsigned operand |
| a_gt_b | output | 1 | op_a greater than op_b |
| a_lt_b | output | 1 | op_a less than op_b |
| a_eq_b | output | 1 | Operands equal |

## Verification
Every 8-bit operand pair is applied, so every possible placement of the first differing bit inside and across groups is covered. A design that let a lower bit through the enable tier would flip results such as 0x80 against 0x7F. The 32-bit instance receives random pairs and also pairs that share all bits above a random position, which exercises the suffix AND across many groups. A broken prefix level there would leave two groups enabled or none, and would give a wrong or double flag. Directed pairs that differ only in bit 0 or only in the top bit catch off-by-one group boundaries and a missing clear at the most significant group.

// File: rtl/pfx_cmp_pkg.sv
package pfx_cmp_pkg;
   // Bits covered by one stop group. The five-input bound of the enable tier depends on it.
   localparam int GROUP_W = 4;

   function automatic int group_count(input int width);
      return width / GROUP_W;
   endfunction

   function automatic int prefix_levels(input int groups);
      return (groups > 1) ? $clog2(groups) : 0;
   endfunction
endpackage

// File: rtl/pfx_cmp_detect.sv
module pfx_cmp_detect
   import pfx_cmp_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0]                 a,
   input  logic [N-1:0]                 b,
   output logic [N-1:0]                 diff,
   output logic [group_count(N)-1:0]    stop
);
   localparam int G = group_count(N);

   // Tier 1: per-bit difference flag
   genvar k;
   generate
      for (k = 0; k < N; k++) begin : g_bit
         assign diff[k] = a[k] ^ b[k];
      end
   endgenerate

   // Tier 2: a group stops lower comparison if any of its bits differ
   genvar g;
   generate
      for (g = 0; g < G; g++) begin : g_grp
         assign stop[g] = |diff[g*GROUP_W +: GROUP_W];
      end
   endgenerate
endmodule

// File: rtl/pfx_cmp_steer.sv
module pfx_cmp_steer
   import pfx_cmp_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0]                 a,
   input  logic [N-1:0]                 b,
   input  logic [N-1:0]                 diff,
   input  logic [group_count(N)-1:0]    stop,
   output logic [N-1:0]                 left_bus,
   output logic [N-1:0]                 right_bus
);
   localparam int G  = group_count(N);
   localparam int LV = prefix_levels(G);

   // Suffix AND of "group is quiet" flags, two-input cells, log depth
   logic [LV:0][G-1:0] quiet_pfx;
   logic [G-1:0]       grp_clear;
   logic [N-1:0]       sel;

   always_comb begin
      quiet_pfx[0] = ~stop;
      for (int l = 1; l <= LV; l++) begin
         for (int g = 0; g < G; g++) begin
            if (g + (1 << (l - 1)) < G)
               quiet_pfx[l][g] = quiet_pfx[l-1][g] & quiet_pfx[l-1][g + (1 << (l - 1))];
            else
               quiet_pfx[l][g] = quiet_pfx[l-1][g];
         end
      end
   end

   genvar g;
   generate
      for (g = 0; g < G; g++) begin : g_clear
         if (g == G - 1) begin : g_top
            assign grp_clear[g] = 1'b1;
         end else begin : g_low
            assign grp_clear[g] = quiet_pfx[LV][g+1];
         end
      end
   endgenerate

   // Tier 3 enable (at most five inputs) and tier 4 steering mux
   genvar k;
   generate
      for (k = 0; k < N; k++) begin : g_bit
         localparam int GI  = k / GROUP_W;
         localparam int POS = k % GROUP_W;
         localparam int TOP = GI * GROUP_W + GROUP_W - 1;
         logic hi_quiet;
         if (POS == GROUP_W - 1) begin : g_edge
            assign hi_quiet = 1'b1;
         end else begin : g_inner
            assign hi_quiet = ~|diff[TOP:k+1];
         end
         assign sel[k]       = diff[k] & hi_quiet & grp_clear[GI];
         assign left_bus[k]  = sel[k] ? a[k] : 1'b0;
         assign right_bus[k] = sel[k] ? b[k] : 1'b0;
      end
   endgenerate

   always_comb begin
      // R8
      sel_onehot_chk: assert ($onehot0(sel))
         else $error("more than one bit position enabled");
      // R8
      bus_disjoint_chk: assert ((left_bus & right_bus) == '0)
         else $error("a position drives both buses");
      // R4
      first_diff_chk: assert ((|diff) == (|sel))
         else $error("difference present but no position enabled, or the reverse");
   end
endmodule

// File: rtl/pfx_cmp_decide.sv
module pfx_cmp_decide
   import pfx_cmp_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0] left_bus,
   input  logic [N-1:0] right_bus,
   output logic         gt,
   output logic         lt,
   output logic         eq
);
   localparam int G = group_count(N);

   logic [G-1:0] left_nor;
   logic [G-1:0] right_nor;

   genvar g;
   generate
      for (g = 0; g < G; g++) begin : g_nor
         assign left_nor[g]  = ~|left_bus[g*GROUP_W +: GROUP_W];
         assign right_nor[g] = ~|right_bus[g*GROUP_W +: GROUP_W];
      end
   endgenerate

   assign gt = ~&left_nor;
   assign lt = ~&right_nor;
   assign eq = ~(gt | lt);

   always_comb begin
      // R8
      flag_excl_chk: assert (!(gt && lt))
         else $error("greater and smaller flags both set");
   end
endmodule

// File: rtl/pfx_mag_cmp.sv
module pfx_mag_cmp
   import pfx_cmp_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0] op_a,
   input  logic [N-1:0] op_b,
   output logic         a_gt_b,
   output logic         a_lt_b,
   output logic         a_eq_b
);
   localparam int G = group_count(N);

   // R7: width must fill whole groups
   generate
      if ((N < GROUP_W) || (N % GROUP_W != 0)) begin : g_bad_width
         $error("pfx_mag_cmp: N must be a positive multiple of 4");
      end
   endgenerate

   logic [N-1:0] diff;
   logic [G-1:0] stop;
   logic [N-1:0] left_bus;
   logic [N-1:0] right_bus;

   pfx_cmp_detect #(.N(N)) u_detect (
      .a    (op_a),
      .b    (op_b),
      .diff (diff),
      .stop (stop)
   );

   pfx_cmp_steer #(.N(N)) u_steer (
      .a         (op_a),
      .b         (op_b),
      .diff      (diff),
      .stop      (stop),
      .left_bus  (left_bus),
      .right_bus (right_bus)
   );

   pfx_cmp_decide #(.N(N)) u_decide (
      .left_bus  (left_bus),
      .right_bus (right_bus),
      .gt        (a_gt_b),
      .lt        (a_lt_b),
      .eq        (a_eq_b)
   );

   always_comb begin
      // R3
      diff_flag_chk: assert ((|stop) == (a_gt_b | a_lt_b))
         else $error("group difference report disagrees with flags");
      // R3
      one_flag_chk: assert ($countones({a_gt_b, a_lt_b, a_eq_b}) == 1)
         else $error("flags not one-hot");
   end
endmodule

// File: tb/pfx_mag_cmp_tb.sv
module pfx_mag_cmp_tb;
   localparam int NW = 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;   // 50 MHz

   logic [7:0]    a8 = '0, b8 = '0;
   logic [NW-1:0] aw = '0, bw = '0;
   logic gt8, lt8, eq8, gtw, ltw, eqw;

   pfx_mag_cmp #(.N(8)) u_dut (
      .op_a(a8), .op_b(b8), .a_gt_b(gt8), .a_lt_b(lt8), .a_eq_b(eq8));

   pfx_mag_cmp #(.N(NW)) u_dut_wide (
      .op_a(aw), .op_b(bw), .a_gt_b(gtw), .a_lt_b(ltw), .a_eq_b(eqw));

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   int cyc   = 0;

   function automatic logic [2:0] exp8(input logic [7:0] a, input logic [7:0] b);
      return {a > b, a < b, a == b};
   endfunction

   function automatic logic [2:0] expw(input logic [NW-1:0] a, input logic [NW-1:0] b);
      return {a > b, a < b, a == b};
   endfunction

   function automatic string tag_of(input logic [2:0] e);
      return e[2] ? "R1" : (e[1] ? "R2" : "R3");
   endfunction

   task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got gt/lt/eq=%b expected %b", req, got, exp);
      end
   endtask

   task automatic apply8(input logic [7:0] a, input logic [7:0] b, input string req);
      @(posedge clk);
      a8 = a; b8 = b;
      @(negedge clk);
      chk(req, {gt8, lt8, eq8}, exp8(a, b));
   endtask

   task automatic applyw(input logic [NW-1:0] a, input logic [NW-1:0] b, input string req);
      @(posedge clk);
      aw = a; bw = b;
      @(negedge clk);
      chk(req, {gtw, ltw, eqw}, expw(a, b));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R3: idle operands are equal
      chk("R3", {gt8, lt8, eq8}, 3'b001);
      chk("R3", {gtw, ltw, eqw}, 3'b001);

      // R4: the top differing bit wins against opposite lower bits
      apply8(8'h80, 8'h7F, "R4");
      apply8(8'h7F, 8'h80, "R4");
      apply8(8'h10, 8'h0F, "R4");
      apply8(8'h08, 8'h07, "R4");
      // R5: LSB-only difference
      apply8(8'hA1, 8'hA0, "R5");
      apply8(8'hA0, 8'hA1, "R5");
      // R6: MSB-only difference
      apply8(8'h80, 8'h00, "R6");
      apply8(8'h55, 8'hD5, "R6");

      // R1 R2 R3: every 8-bit pair
      for (int i = 0; i < 65536; i++) begin
         logic [7:0] a, b;
         logic [2:0] e;
         a = i[15:8];
         b = i[7:0];
         e = exp8(a, b);
         @(posedge clk);
         a8 = a; b8 = b;
         @(negedge clk);
         chk(tag_of(e), {gt8, lt8, eq8}, e);
         if ($countones({gt8, lt8, eq8}) != 1)
            chk("R8", {gt8, lt8, eq8}, e);
      end

      // R7: wide instance, directed corners
      applyw(32'h8000_0000, 32'h7FFF_FFFF, "R7");
      applyw(32'h0000_0001, 32'h0000_0000, "R7");
      applyw(32'h1234_5678, 32'h1234_5679, "R7");
      applyw(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7");
      applyw(32'h0001_0000, 32'h0000_FFFF, "R7");

      // R7: wide random pairs
      for (int i = 0; i < 2000; i++) begin
         applyw($urandom, $urandom, "R7");
      end

      // R7 R4: pairs sharing all bits above a random position
      for (int i = 0; i < 2000; i++) begin
         logic [NW-1:0] a, b, mask;
         int p;
         p = $urandom_range(NW - 1, 0);
         a = $urandom;
         mask = (p == NW - 1) ? '1 : ((NW'(1) << (p + 1)) - NW'(1));
         b = (a & ~mask) | (NW'($urandom) & mask);
         b[p] = ~a[p];
         applyw(a, b, "R4");
      end

      finish_run();
   end
endmodule